// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Port

This block is a full-duplex asynchronous serial port for a small 8-bit controller. Software reaches it over a simple special-function-register bus with two addresses. One is a control/status register that holds the framing mode, the receive enable, the ninth-bit values and the two completion flags. The other is a shared data address. A write to the data address loads the transmit shifter and starts a frame. A read of the same address returns the receive holding register, which is a separate piece of storage.

The receiver has two stages: a shift register and a holding register. A new frame can be shifted in while the previous byte still waits in the holding register. Bit timing comes from an external `baud_tick` strobe running at sixteen ticks per bit period, for example a timer overflow. The transmit and receive paths each count these ticks on their own, so both directions run at the same time. Two framings are available: eight data bits, or nine data bits where the ninth bit comes from a control bit.

Top module: `dbuart`

## Requirements
- R1: After reset, `txd` is high, the control register reads 0x00 and the data address reads 0x00.
- R2: The control register layout is: bit5 is the mode (1 = nine data bits), bit4 is the receive enable, bit3 is the ninth transmit bit, bit2 is the ninth received bit (read-only), bit1 is the transmit-done flag and bit0 is the receive-done flag. Bits 7:6 read 0. A write stores the written values of bits 5, 4, 3, 1 and 0.
- R3: A write to the data address while the transmitter is idle drives `txd` low on the next clock for 16 ticks. The data bits follow LSB first, 16 ticks each, then a high stop bit of 16 ticks. `txd` is high whenever the transmitter is idle.
- R4: A write to the data address while a frame is being sent is ignored. The frame in flight is unchanged and no further frame follows.
- R5: The transmit-done flag (bit1) sets when the stop bit begins. It stays set until software writes 0 to it.
- R6: A read of the data address returns the receive holding register, never the byte last written for transmission. `sfr_rdata` updates on the clock after the read strobe and holds its value while no read is strobed.
- R7: With the receive enable set, a low line seen on a tick starts a frame. Each bit is the majority of the samples at ticks 7, 8 and 9 of its 16-tick period. At the middle of the stop bit, if the receive-done flag (bit0) is clear, the byte is copied into the holding register and the flag sets.
- R8: A start bit that reads high at tick 8 is abandoned. No byte is delivered, and the receiver accepts the next frame normally.
- R9: While a new frame is shifting in, the holding register keeps the unread previous byte. The new byte replaces it only when that frame completes with the flag clear.
- R10: A frame that completes while the receive-done flag is still set is discarded. The holding register and the ninth received bit keep their values.
- R11: In nine-bit mode, the transmitter sends bit3 as the ninth data bit, and the ninth received bit is stored in bit2.
- R12: With the receive enable clear, the receiver ignores the line, and neither the holding register nor the receive-done flag changes.
- R13: A transmit frame and a receive frame in progress at the same time both complete correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-clock strobe, 16 per bit period |
| sfr_addr | input | ADDR_W | Register-bus address |
| sfr_wr | input | 1 | Register write strobe |
| sfr_wdata | input | DATA_W | Register write data |
| sfr_rd | input | 1 | Register read strobe |
| sfr_rdata | output | DATA_W | Registered read data |
| rxd | input | 1 | Serial input line, asynchronous |
| txd | output | 1 | Serial output line, registered |

## Verification
The assertions check several rules on every cycle. The line is high whenever the transmitter is idle. The transmit flag follows the start of every stop bit. A completed receive frame either sets the flag or, when the flag was already set, leaves the holding register untouched. A disabled receiver delivers nothing. Read data only moves on a read strobe, and the top control bits read zero. Other behaviours can only be shown by the bench's scenarios: bit order and frame length on the line, majority sampling, start-bit rejection, double buffering while software reads late, the ninth bit in both directions, and simultaneous traffic in both directions.

// File: rtl/dbuart_pkg.sv
package dbuart_pkg;

  // Control register bit positions (software-visible layout)
  localparam int unsigned CTL_RXF  = 0;
  localparam int unsigned CTL_TXF  = 1;
  localparam int unsigned CTL_RX9  = 2;
  localparam int unsigned CTL_TX9  = 3;
  localparam int unsigned CTL_REN  = 4;
  localparam int unsigned CTL_MODE = 5;
  localparam int unsigned CTL_BITS = 6;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_START,
    PH_DATA,
    PH_STOP
  } frame_phase_e;

  // Packed so that field order matches the bit positions above
  typedef struct packed {
    logic mode9;
    logic ren;
    logic tx9;
    logic rx9;
    logic txf;
    logic rxf;
  } ctl_t;

endpackage

// File: rtl/dbuart_sync.sv
module dbuart_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] ff;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) ff <= '1;
        else     ff <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) ff <= '1;
        else     ff <= {ff[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = ff[STAGES-1];

endmodule

// File: rtl/dbuart_tx.sv
module dbuart_tx
  import dbuart_pkg::*;
#(
  parameter int unsigned OSR    = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              load,
  input  logic              mode9,
  input  logic              tx9,
  input  logic [DATA_W-1:0] din,
  output logic              txd,
  output logic              busy,
  output logic              stop_begin
);

  localparam int unsigned CW = $clog2(OSR);
  localparam int unsigned IW = $clog2(DATA_W + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(OSR - 1);

  frame_phase_e  ph;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;
  logic [DATA_W:0] sh;
  logic          m9;
  logic [IW-1:0] last_idx;
  logic          wrap;

  assign last_idx = m9 ? IW'(DATA_W) : IW'(DATA_W - 1);
  assign wrap     = tick && (cnt == CNT_LAST);
  assign busy     = (ph != PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph         <= PH_IDLE;
      cnt        <= '0;
      idx        <= '0;
      sh         <= '0;
      m9         <= 1'b0;
      txd        <= 1'b1;
      stop_begin <= 1'b0;
    end else begin
      stop_begin <= 1'b0;
      if (ph == PH_IDLE) begin
        if (load) begin
          ph  <= PH_START;
          sh  <= {tx9, din};
          m9  <= mode9;
          cnt <= '0;
          idx <= '0;
          txd <= 1'b0;
        end
      end else begin
        if (tick) cnt <= wrap ? '0 : cnt + 1'b1;
        if (wrap) begin
          case (ph)
            PH_START: begin
              ph  <= PH_DATA;
              txd <= sh[0];
            end
            PH_DATA: begin
              if (idx == last_idx) begin
                ph         <= PH_STOP;
                txd        <= 1'b1;
                stop_begin <= 1'b1;
              end else begin
                idx <= idx + 1'b1;
                sh  <= sh >> 1;
                txd <= sh[1];
              end
            end
            default: ph <= PH_IDLE;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/dbuart_rx.sv
module dbuart_rx
  import dbuart_pkg::*;
#(
  parameter int unsigned OSR    = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            en,
  input  logic            mode9,
  input  logic            rxs,
  output logic            done,
  output logic [DATA_W:0] word
);

  localparam int unsigned CW  = $clog2(OSR);
  localparam int unsigned IW  = $clog2(DATA_W + 1);
  localparam int unsigned MID = OSR / 2;
  localparam logic [CW-1:0] CNT_LAST = CW'(OSR - 1);
  localparam logic [CW-1:0] P_LO     = CW'(MID - 1);
  localparam logic [CW-1:0] P_MID    = CW'(MID);
  localparam logic [CW-1:0] P_HI     = CW'(MID + 1);

  frame_phase_e  ph;
  logic [CW-1:0] cnt;
  logic [CW-1:0] nxt;
  logic [IW-1:0] idx;
  logic [IW-1:0] last_idx;
  logic          m9;
  logic          v_lo;
  logic          v_mid;
  logic          vote;

  assign nxt      = (cnt == CNT_LAST) ? '0 : cnt + 1'b1;
  assign last_idx = m9 ? IW'(DATA_W) : IW'(DATA_W - 1);
  assign vote     = (v_lo & v_mid) | (v_lo & rxs) | (v_mid & rxs);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph    <= PH_IDLE;
      cnt   <= '0;
      idx   <= '0;
      m9    <= 1'b0;
      v_lo  <= 1'b1;
      v_mid <= 1'b1;
      word  <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!en) begin
        ph <= PH_IDLE;
      end else if (ph == PH_IDLE) begin
        if (tick && !rxs) begin
          ph   <= PH_START;
          cnt  <= '0;
          idx  <= '0;
          m9   <= mode9;
          word <= '0;
        end
      end else if (tick) begin
        cnt <= nxt;
        if (nxt == P_LO)  v_lo  <= rxs;
        if (nxt == P_MID) v_mid <= rxs;
        case (ph)
          PH_START: begin
            if (nxt == P_MID && rxs) ph <= PH_IDLE;
            else if (nxt == '0)      ph <= PH_DATA;
          end
          PH_DATA: begin
            if (nxt == P_HI) word[idx] <= vote;
            if (nxt == '0) begin
              if (idx == last_idx) ph  <= PH_STOP;
              else                 idx <= idx + 1'b1;
            end
          end
          default: begin
            if (nxt == P_HI) begin
              done <= 1'b1;
              ph   <= PH_IDLE;
            end
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/dbuart_regs.sv
module dbuart_regs
  import dbuart_pkg::*;
#(
  parameter int unsigned    ADDR_W    = 8,
  parameter int unsigned    DATA_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h50,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h51
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic              sfr_wr,
  input  logic [DATA_W-1:0] sfr_wdata,
  input  logic              sfr_rd,
  output logic [DATA_W-1:0] sfr_rdata,
  input  logic              tx_busy,
  input  logic              tx_stop,
  input  logic              rx_done,
  input  logic [DATA_W:0]   rx_word,
  output logic              tx_load,
  output logic              mode9,
  output logic              tx9,
  output logic              ren,
  output logic              txf,
  output logic              rxf,
  output logic [DATA_W-1:0] hold
);

  ctl_t ctl;
  logic wr_ctl, wr_dat, rd_ctl, rd_dat, rx_take;
  logic unused_wbits;

  assign wr_ctl  = sfr_wr && (sfr_addr == CTRL_ADDR);
  assign wr_dat  = sfr_wr && (sfr_addr == DATA_ADDR);
  assign rd_ctl  = sfr_rd && (sfr_addr == CTRL_ADDR);
  assign rd_dat  = sfr_rd && (sfr_addr == DATA_ADDR);
  assign tx_load = wr_dat && !tx_busy;
  assign rx_take = rx_done && !ctl.rxf;

  assign unused_wbits = ^{sfr_wdata[DATA_W-1:CTL_BITS], sfr_wdata[CTL_RX9]};

  assign mode9 = ctl.mode9;
  assign tx9   = ctl.tx9;
  assign ren   = ctl.ren;
  assign txf   = ctl.txf;
  assign rxf   = ctl.rxf;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl       <= '0;
      hold      <= '0;
      sfr_rdata <= '0;
    end else begin
      if (wr_ctl) begin
        ctl.mode9 <= sfr_wdata[CTL_MODE];
        ctl.ren   <= sfr_wdata[CTL_REN];
        ctl.tx9   <= sfr_wdata[CTL_TX9];
        ctl.txf   <= sfr_wdata[CTL_TXF];
        ctl.rxf   <= sfr_wdata[CTL_RXF];
      end
      // hardware set wins over a software write in the same cycle
      if (tx_stop) ctl.txf <= 1'b1;
      if (rx_take) begin
        ctl.rxf <= 1'b1;
        ctl.rx9 <= rx_word[DATA_W];
        hold    <= rx_word[DATA_W-1:0];
      end
      if (rd_ctl)      sfr_rdata <= DATA_W'(ctl);
      else if (rd_dat) sfr_rdata <= hold;
    end
  end

endmodule

// File: rtl/dbuart.sv
module dbuart
  import dbuart_pkg::*;
#(
  parameter int unsigned       ADDR_W      = 8,
  parameter int unsigned       DATA_W      = 8,
  parameter int unsigned       OSR         = 16,
  parameter int unsigned       SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] CTRL_ADDR   = 8'h50,
  parameter logic [ADDR_W-1:0] DATA_ADDR   = 8'h51
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_tick,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic              sfr_wr,
  input  logic [DATA_W-1:0] sfr_wdata,
  input  logic              sfr_rd,
  output logic [DATA_W-1:0] sfr_rdata,
  input  logic              rxd,
  output logic              txd
);

  logic              rxs;
  logic              tx_busy, tx_stop, tx_load;
  logic              rx_done;
  logic [DATA_W:0]   rx_word;
  logic              mode9, tx9, ren, txf, rxf;
  logic [DATA_W-1:0] hold;

  dbuart_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (rxd),
    .q   (rxs)
  );

  dbuart_regs #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .CTRL_ADDR (CTRL_ADDR),
    .DATA_ADDR (DATA_ADDR)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .sfr_addr  (sfr_addr),
    .sfr_wr    (sfr_wr),
    .sfr_wdata (sfr_wdata),
    .sfr_rd    (sfr_rd),
    .sfr_rdata (sfr_rdata),
    .tx_busy   (tx_busy),
    .tx_stop   (tx_stop),
    .rx_done   (rx_done),
    .rx_word   (rx_word),
    .tx_load   (tx_load),
    .mode9     (mode9),
    .tx9       (tx9),
    .ren       (ren),
    .txf       (txf),
    .rxf       (rxf),
    .hold      (hold)
  );

  dbuart_tx #(.OSR(OSR), .DATA_W(DATA_W)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .tick       (baud_tick),
    .load       (tx_load),
    .mode9      (mode9),
    .tx9        (tx9),
    .din        (sfr_wdata),
    .txd        (txd),
    .busy       (tx_busy),
    .stop_begin (tx_stop)
  );

  dbuart_rx #(.OSR(OSR), .DATA_W(DATA_W)) u_rx (
    .clk   (clk),
    .rst   (rst),
    .tick  (baud_tick),
    .en    (ren),
    .mode9 (mode9),
    .rxs   (rxs),
    .done  (rx_done),
    .word  (rx_word)
  );

endmodule

// File: rtl/dbuart_chk.sv
module dbuart_chk #(
  parameter int unsigned       ADDR_W    = 8,
  parameter int unsigned       DATA_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h50
) (
  input logic              clk,
  input logic              rst,
  input logic              sfr_rd,
  input logic [ADDR_W-1:0] sfr_addr,
  input logic [DATA_W-1:0] sfr_rdata,
  input logic              txd,
  input logic              tx_busy,
  input logic              tx_stop,
  input logic              txf,
  input logic              rx_done,
  input logic              rxf,
  input logic              ren,
  input logic [DATA_W-1:0] hold
);

  AST_TX_IDLE_MARK: assert property (@(posedge clk) disable iff (rst)
    !tx_busy |-> txd); // R3

  AST_STOP_IS_HIGH: assert property (@(posedge clk) disable iff (rst)
    tx_stop |-> txd); // R3

  AST_TXF_AT_STOP: assert property (@(posedge clk) disable iff (rst)
    tx_stop |=> txf); // R5

  AST_RX_TAKE: assert property (@(posedge clk) disable iff (rst)
    (rx_done && !rxf) |=> rxf); // R7

  AST_RX_DISCARD: assert property (@(posedge clk) disable iff (rst)
    (rx_done && rxf) |=> $stable(hold)); // R10

  AST_RX_DISABLED: assert property (@(posedge clk) disable iff (rst)
    !ren |=> !rx_done); // R12

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !sfr_rd |=> $stable(sfr_rdata)); // R6

  AST_CTRL_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (sfr_rd && sfr_addr == CTRL_ADDR) |=> ((sfr_rdata >> 6) == '0)); // R2

endmodule

bind dbuart dbuart_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .CTRL_ADDR (CTRL_ADDR)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sfr_rd    (sfr_rd),
  .sfr_addr  (sfr_addr),
  .sfr_rdata (sfr_rdata),
  .txd       (txd),
  .tx_busy   (tx_busy),
  .tx_stop   (tx_stop),
  .txf       (txf),
  .rx_done   (rx_done),
  .rxf       (rxf),
  .ren       (ren),
  .hold      (hold)
);

// File: tb/test_dbuart.sv
`timescale 1ns/1ps
module test_dbuart;

  localparam int unsigned TICK_DIV = 4;
  localparam logic [7:0]  CA = 8'h50;
  localparam logic [7:0]  DA = 8'h51;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       baud_tick = 1'b0;
  logic [7:0] sfr_addr = 8'h00;
  logic       sfr_wr = 1'b0;
  logic [7:0] sfr_wdata = 8'h00;
  logic       sfr_rd = 1'b0;
  logic [7:0] sfr_rdata;
  logic       rxd = 1'b1;
  logic       txd;

  int checks = 0;
  int failures = 0;
  int mon_last_data = 0;
  int mon_frames = 0;
  bit finished = 0;
  logic [9:0] txq[$];   // {nine_bit_mode, 9-bit value}

  always #4 clk = ~clk;  // 125 MHz

  dbuart i_dbuart (
    .clk(clk), .rst(rst), .baud_tick(baud_tick),
    .sfr_addr(sfr_addr), .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata),
    .sfr_rd(sfr_rd), .sfr_rdata(sfr_rdata), .rxd(rxd), .txd(txd)
  );

  initial begin : tick_gen
    int c;
    c = 0;
    forever begin
      @(negedge clk);
      #1;
      c = (c == TICK_DIV - 1) ? 0 : c + 1;
      baud_tick = (c == 0);
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic wait_ticks(input int n);
    int k;
    k = 0;
    while (k < n) begin
      @(negedge clk);
      if (baud_tick) k++;
    end
  endtask

  task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); #2;
    sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
    @(negedge clk); #2;
    sfr_wr = 1'b0;
  endtask

  task automatic sfr_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); #2;
    sfr_addr = a; sfr_rd = 1'b1;
    @(negedge clk); #2;
    sfr_rd = 1'b0;
    d = sfr_rdata;
  endtask

  task automatic expect_reg(input string req, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] v;
    sfr_read(a, v);
    chk(req, {24'h0, v}, {24'h0, exp});
  endtask

  task automatic rx_frame(input logic [8:0] v, input int nbits);
    wait_ticks(1);
    #2 rxd = 1'b0;
    wait_ticks(16);
    for (int i = 0; i < nbits; i++) begin
      #2 rxd = v[i];
      wait_ticks(16);
    end
    #2 rxd = 1'b1;
    wait_ticks(16);
  endtask

  // Monitor: decodes frames on txd and compares with the scoreboard queue
  initial begin : tx_monitor
    logic prev_l;
    prev_l = 1'b1;
    forever begin
      @(negedge clk);
      if (!rst && prev_l && (txd === 1'b0)) begin : decode
        logic [9:0]  item;
        logic [10:0] seen;
        int nb;
        int t;
        seen = '0;
        if (txq.size() == 0) begin
          chk("R4 unexpected frame", 1, 0);
          item = 10'h0;
        end else begin
          item = txq.pop_front();
        end
        nb = item[9] ? 9 : 8;
        t = 0;
        for (int j = 0; j < nb + 2; j++) begin
          while (t < 8 + 16 * j) begin
            @(negedge clk);
            if (baud_tick) t++;
          end
          seen[j] = txd;
          if (j == nb) mon_last_data++;
        end
        chk("R3 start bit", {31'h0, seen[0]}, 0);
        if (item[9]) chk("R11 nine-bit frame data", {23'h0, seen[9:1]}, {23'h0, item[8:0]});
        else         chk("R3 frame data", {24'h0, seen[8:1]}, {24'h0, item[7:0]});
        chk("R3 stop bit", {31'h0, seen[nb+1]}, 1);
        mon_frames++;
      end
      prev_l = txd;
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      report();
    end
  end

  initial begin : main
    logic [7:0] v;
    repeat (5) @(negedge clk);
    #2 rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    chk("R1 txd idle", {31'h0, txd}, 1);
    expect_reg("R1 ctrl", CA, 8'h00);
    expect_reg("R1 data", DA, 8'h00);

    // R2: layout; rx9 read-only, upper bits zero
    sfr_write(CA, 8'hFF);
    expect_reg("R2 write all ones", CA, 8'h3B);
    sfr_write(CA, 8'h10);
    expect_reg("R2 enable only", CA, 8'h10);

    // R3/R4/R5/R6: basic transmit
    txq.push_back({1'b0, 9'h0A5});
    sfr_write(DA, 8'hA5);
    expect_reg("R5 flag clear while sending", CA, 8'h10);
    expect_reg("R6 data read is holding reg", DA, 8'h00);
    sfr_write(DA, 8'h3C);            // R4: busy, must be ignored
    wait (mon_last_data == 1);
    expect_reg("R5 flag clear in last data bit", CA, 8'h10);
    wait (mon_frames == 1);
    expect_reg("R5 flag set after stop start", CA, 8'h12);
    wait_ticks(60);
    expect_reg("R5 flag stays set", CA, 8'h12);
    chk("R4 single frame only", mon_frames, 1);
    sfr_write(CA, 8'h10);
    expect_reg("R5 flag cleared by software", CA, 8'h10);

    // R7: basic receive
    rx_frame(9'h05A, 8);
    expect_reg("R7 rx flag", CA, 8'h11);
    expect_reg("R7 rx data", DA, 8'h5A);
    sfr_write(CA, 8'h10);

    // R9: double buffering
    rx_frame(9'h011, 8);
    fork
      rx_frame(9'h022, 8);
      begin
        wait_ticks(60);
        expect_reg("R9 old byte kept during shift", DA, 8'h11);
        expect_reg("R9 flag still set", CA, 8'h11);
        sfr_write(CA, 8'h10);
      end
    join
    expect_reg("R9 new byte delivered", DA, 8'h22);
    expect_reg("R9 flag set again", CA, 8'h11);
    sfr_write(CA, 8'h10);

    // R10: overrun discard
    rx_frame(9'h033, 8);
    rx_frame(9'h044, 8);
    expect_reg("R10 first byte kept", DA, 8'h33);
    sfr_write(CA, 8'h10);
    wait_ticks(40);
    expect_reg("R10 no late delivery", CA, 8'h10);
    expect_reg("R10 holding unchanged", DA, 8'h33);

    // R8: false start
    wait_ticks(1);
    #2 rxd = 1'b0;
    wait_ticks(4);
    #2 rxd = 1'b1;
    wait_ticks(40);
    expect_reg("R8 no byte from glitch", CA, 8'h10);
    rx_frame(9'h066, 8);
    expect_reg("R8 next frame received", DA, 8'h66);
    sfr_write(CA, 8'h10);

    // R12: receiver disabled
    sfr_write(CA, 8'h00);
    rx_frame(9'h077, 8);
    expect_reg("R12 flag untouched", CA, 8'h00);
    expect_reg("R12 holding untouched", DA, 8'h66);

    // R11/R13: nine-bit mode, both directions at once
    sfr_write(CA, 8'h38);
    txq.push_back({1'b1, 9'h1C3});
    fork
      sfr_write(DA, 8'hC3);
      rx_frame(9'h181, 9);
    join
    wait (mon_frames == 2);
    wait_ticks(12);
    expect_reg("R13 both flags, R11 rx9 set", CA, 8'h3F);
    expect_reg("R11 nine-bit rx data", DA, 8'h81);
    sfr_write(CA, 8'h38);
    rx_frame(9'h05E, 9);
    expect_reg("R11 rx9 clear", CA, 8'h39);
    expect_reg("R11 rx data second", DA, 8'h5E);
    sfr_write(CA, 8'h30);
    txq.push_back({1'b1, 9'h00F});
    sfr_write(DA, 8'h0F);
    wait (mon_frames == 3);
    wait_ticks(12);

    // R13: eight-bit mode, both directions at once
    sfr_write(CA, 8'h10);
    txq.push_back({1'b0, 9'h096});
    fork
      sfr_write(DA, 8'h96);
      rx_frame(9'h069, 8);
    join
    wait (mon_frames == 4);
    wait_ticks(12);
    expect_reg("R13 duplex flags", CA, 8'h13);
    expect_reg("R13 duplex rx data", DA, 8'h69);
    chk("R3 all expected frames sent", txq.size(), 0);

    finished = 1;
    report();
  end

endmodule